// File: doc/BRIEF.md
# Instruction-Driven Multiply-Add Sequencing Controller

This block sits between a host processor and a registered multiply-add datapath that has two operand memories around it. The host writes a 32-bit instruction word and raises a start level. The controller takes the word apart into an ALU mode, an operand-select mode, an input mode and three 5-bit memory addresses. It then steps one operation through a four-state sequence and raises a valid flag when the operation is complete. Valid stays high until the host drops start.

A write-back strobe is issued once per operation and is delayed through a chain of registers, together with the result write address. This lines the write up with the datapath's own register stages. The result memory has a single address port that is used both to read the second operand and to write the result back. A two-way selector puts the delayed write address on that port while the delayed strobe is high, and the live read address at all other times.

Top module: `dspseq_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the sequencer in its idle state. After reset, `valid_o`, `res_we_o`, every decoded field and every enable read 0, and `res_addr_o` reads 0.
- R2: In idle the cycle counter is held at zero. The clock edge that samples `start_i` high moves the sequencer to decode, and the following edge moves it to execute.
- R3: Fields are taken from the instruction as follows: bits 30:27 give `alu_mode_o`, bits 26:20 give `opsel_o`, bits 19:15 give `inmode_o`, bits 14:10 give the result write address, bits 9:5 give `res_rd_addr_o`, and bits 4:0 give `op_rd_addr_o`.
- R4: Instruction bit 31 drives `op_rd_en_o`, `res_en_o` and the result write enable, all three together.
- R5: Decoded outputs are loaded on the edge that leaves decode. They then hold steady through execute and done, whatever `instr_i` does. They return to 0 on the edge that goes back to idle.
- R6: Execute lasts exactly 4 cycles. `valid_o` is first seen high 6 cycles after the cycle in which `start_i` is first presented high.
- R7: `valid_o` is high only in the done state. Done is kept for as long as `start_i` stays high, and the sequencer returns to idle on the first edge that samples `start_i` low.
- R8: When bit 31 is set, `res_we_o` pulses high for exactly one cycle per operation. The pulse comes 3 register stages after the first execute cycle, which places it in the last execute cycle. When bit 31 is clear, `res_we_o` never rises.
- R9: `res_addr_o` equals the result write address (bits 14:10) while `res_we_o` is high, and equals `res_rd_addr_o` otherwise.
- R10: A reset applied in the middle of an operation clears the delay chain, the counter and valid on the next edge, so no stale write strobe appears afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start level from the host |
| instr_i | input | 32 | Instruction word |
| valid_o | output | 1 | Operation complete |
| alu_mode_o | output | 4 | Decoded ALU mode |
| opsel_o | output | 7 | Decoded operand-select mode |
| inmode_o | output | 5 | Decoded input mode |
| op_rd_en_o | output | 1 | Operand memory read enable |
| op_rd_addr_o | output | 5 | Operand memory read address |
| res_en_o | output | 1 | Result memory port enable |
| res_rd_addr_o | output | 5 | Live result memory read address |
| res_we_o | output | 1 | Delayed result write strobe |
| res_addr_o | output | 5 | Shared result memory port address |

## Verification
The bench goes after the timing of the write strobe. A chain that is one stage short or one stage long would move the pulse out of the last execute cycle, and if the strobe were tied to the held enable, the pulse would stretch across several cycles. The bench changes the instruction while execute is running. A design that reloads its fields after decode would then show different field values. The bench also holds start through done and then drops it after a single cycle, which exposes a done state that leaves too early or sticks. A reset in the middle of an operation would leave a stray write strobe behind if the delay chain were not cleared. Finally, the address selector is checked on every cycle, both with and without a write pending.

// File: rtl/dspseq_pkg.sv
package dspseq_pkg;

    localparam int INSTR_W  = 32;
    localparam int ADDR_W   = 5;
    localparam int ALU_W    = 4;
    localparam int OPSEL_W  = 7;
    localparam int INMODE_W = 5;

    // Field positions of the instruction word (behavioural: host encodes them)
    localparam int EN_BIT      = 31;
    localparam int ALU_LSB     = 27;
    localparam int OPSEL_LSB   = 20;
    localparam int INMODE_LSB  = 15;
    localparam int WADDR_LSB   = 10;
    localparam int RRADDR_LSB  = 5;
    localparam int OPADDR_LSB  = 0;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DECODE = 2'd1,
        ST_EXEC   = 2'd2,
        ST_DONE   = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic                en;
        logic [ALU_W-1:0]    alu;
        logic [OPSEL_W-1:0]  opsel;
        logic [INMODE_W-1:0] inmode;
        logic [ADDR_W-1:0]   wr_addr;
        logic [ADDR_W-1:0]   res_rd_addr;
        logic [ADDR_W-1:0]   op_rd_addr;
    } op_ctrl_t;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
    } wb_tag_t;

    localparam int WB_TAG_W = $bits(wb_tag_t);

    function automatic op_ctrl_t decode_instr(input logic [INSTR_W-1:0] w);
        op_ctrl_t c;
        c.en          = w[EN_BIT];
        c.alu         = w[ALU_LSB    +: ALU_W];
        c.opsel       = w[OPSEL_LSB  +: OPSEL_W];
        c.inmode      = w[INMODE_LSB +: INMODE_W];
        c.wr_addr     = w[WADDR_LSB  +: ADDR_W];
        c.res_rd_addr = w[RRADDR_LSB +: ADDR_W];
        c.op_rd_addr  = w[OPADDR_LSB +: ADDR_W];
        return c;
    endfunction

endpackage

// File: rtl/dspseq_fsm.sv
module dspseq_fsm
    import dspseq_pkg::*;
#(
    parameter int EXEC_CYCLES = 4,
    localparam int CNT_W = (EXEC_CYCLES > 1) ? $clog2(EXEC_CYCLES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    output seq_state_e       state_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             load_o,
    output logic             clear_o,
    output logic             first_exec_o,
    output logic             valid_o
);

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(EXEC_CYCLES - 1);

    seq_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (start_i) st_d = ST_DECODE;
            end
            ST_DECODE: begin
                cnt_d = '0;
                st_d  = ST_EXEC;
            end
            ST_EXEC: begin
                if (cnt_q == CNT_LAST) begin
                    cnt_d = '0;
                    st_d  = ST_DONE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_DONE: begin
                cnt_d = '0;
                if (!start_i) st_d = ST_IDLE;
            end
            default: begin
                st_d  = ST_IDLE;
                cnt_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign state_o      = st_q;
    assign cnt_o        = cnt_q;
    assign load_o       = (st_q == ST_DECODE);
    assign clear_o      = (st_q == ST_DONE) && !start_i;
    assign first_exec_o = (st_q == ST_EXEC) && (cnt_q == '0);
    assign valid_o      = (st_q == ST_DONE);

endmodule

// File: rtl/dspseq_ctrl_reg.sv
module dspseq_ctrl_reg
    import dspseq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load_i,
    input  logic               clear_i,
    input  logic [INSTR_W-1:0] instr_i,
    output op_ctrl_t           ctrl_o
);

    op_ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            ctrl_q <= '0;
        end else if (load_i) begin
            ctrl_q <= decode_instr(instr_i);
        end
    end

    assign ctrl_o = ctrl_q;

endmodule

// File: rtl/dspseq_delay_line.sv
module dspseq_delay_line #(
    parameter int WIDTH = 6,
    parameter int DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stg_q [DEPTH];

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_stage
            if (gi == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) stg_q[gi] <= '0;
                    else     stg_q[gi] <= d_i;
                end
            end else begin : g_tail
                always_ff @(posedge clk) begin
                    if (rst) stg_q[gi] <= '0;
                    else     stg_q[gi] <= stg_q[gi-1];
                end
            end
        end
    endgenerate

    assign q_o = stg_q[DEPTH-1];

endmodule

// File: rtl/dspseq_addr_mux.sv
module dspseq_addr_mux #(
    parameter int AW = 5
) (
    input  logic          sel_wr_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [AW-1:0] addr_o
);

    always_comb begin
        if (sel_wr_i) addr_o = wr_addr_i;
        else          addr_o = rd_addr_i;
    end

endmodule

// File: rtl/dspseq_ctrl.sv
module dspseq_ctrl
    import dspseq_pkg::*;
#(
    parameter int EXEC_CYCLES = 4,
    parameter int WB_DEPTH    = 3,
    localparam int CNT_W = (EXEC_CYCLES > 1) ? $clog2(EXEC_CYCLES) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [INSTR_W-1:0]  instr_i,
    output logic                valid_o,
    output logic [ALU_W-1:0]    alu_mode_o,
    output logic [OPSEL_W-1:0]  opsel_o,
    output logic [INMODE_W-1:0] inmode_o,
    output logic                op_rd_en_o,
    output logic [ADDR_W-1:0]   op_rd_addr_o,
    output logic                res_en_o,
    output logic [ADDR_W-1:0]   res_rd_addr_o,
    output logic                res_we_o,
    output logic [ADDR_W-1:0]   res_addr_o
);

    seq_state_e       st;
    logic [CNT_W-1:0] cnt;
    logic             load, clear, first_exec;
    op_ctrl_t         ctrl;
    wb_tag_t          wb_live, wb_dly;
    logic [WB_TAG_W-1:0] wb_dly_bits;

    dspseq_fsm #(.EXEC_CYCLES(EXEC_CYCLES)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .state_o      (st),
        .cnt_o        (cnt),
        .load_o       (load),
        .clear_o      (clear),
        .first_exec_o (first_exec),
        .valid_o      (valid_o)
    );

    dspseq_ctrl_reg u_creg (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load),
        .clear_i (clear),
        .instr_i (instr_i),
        .ctrl_o  (ctrl)
    );

    always_comb begin
        wb_live.we   = ctrl.en && first_exec;
        wb_live.addr = ctrl.wr_addr;
    end

    dspseq_delay_line #(.WIDTH(WB_TAG_W), .DEPTH(WB_DEPTH)) u_wb_dly (
        .clk (clk),
        .rst (rst),
        .d_i (wb_live),
        .q_o (wb_dly_bits)
    );

    assign wb_dly = wb_tag_t'(wb_dly_bits);

    dspseq_addr_mux #(.AW(ADDR_W)) u_amux (
        .sel_wr_i  (wb_dly.we),
        .wr_addr_i (wb_dly.addr),
        .rd_addr_i (ctrl.res_rd_addr),
        .addr_o    (res_addr_o)
    );

    assign alu_mode_o    = ctrl.alu;
    assign opsel_o       = ctrl.opsel;
    assign inmode_o      = ctrl.inmode;
    assign op_rd_en_o    = ctrl.en;
    assign op_rd_addr_o  = ctrl.op_rd_addr;
    assign res_en_o      = ctrl.en;
    assign res_rd_addr_o = ctrl.res_rd_addr;
    assign res_we_o      = wb_dly.we;

endmodule

// File: rtl/dspseq_ctrl_chk.sv
module dspseq_ctrl_chk #(
    parameter int EXEC_CYCLES = 4,
    localparam int CNT_W = (EXEC_CYCLES > 1) ? $clog2(EXEC_CYCLES) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             valid_o,
    input logic [3:0]       alu_mode_o,
    input logic [6:0]       opsel_o,
    input logic [4:0]       inmode_o,
    input logic             op_rd_en_o,
    input logic             res_en_o,
    input logic             res_we_o,
    input logic [1:0]       state,
    input logic [CNT_W-1:0] cnt
);

    localparam logic [1:0] S_EXEC = 2'd2;

    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (!valid_o && !res_we_o && !res_en_o));

    p_done_holds_r7: assert property (@(posedge clk) disable iff (rst)
        (valid_o && start_i) |=> valid_o);

    p_done_leaves_r7: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !start_i) |=> !valid_o);

    p_fields_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (valid_o && $past(valid_o)) |->
            ($stable(alu_mode_o) && $stable(opsel_o) && $stable(inmode_o)));

    p_enables_together_r4: assert property (@(posedge clk) disable iff (rst)
        op_rd_en_o == res_en_o);

    p_we_single_r8: assert property (@(posedge clk) disable iff (rst)
        res_we_o |=> !res_we_o);

    p_we_in_last_exec_r8: assert property (@(posedge clk) disable iff (rst)
        res_we_o |-> (state == S_EXEC && cnt == CNT_W'(EXEC_CYCLES - 1) && res_en_o));

    p_valid_after_exec_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(valid_o) |-> ($past(state) == S_EXEC));

endmodule

bind dspseq_ctrl dspseq_ctrl_chk #(.EXEC_CYCLES(EXEC_CYCLES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .valid_o    (valid_o),
    .alu_mode_o (alu_mode_o),
    .opsel_o    (opsel_o),
    .inmode_o   (inmode_o),
    .op_rd_en_o (op_rd_en_o),
    .res_en_o   (res_en_o),
    .res_we_o   (res_we_o),
    .state      (st),
    .cnt        (cnt)
);

// File: tb/dspseq_ctrl_test.sv
module dspseq_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic        valid_o;
    logic [3:0]  alu_mode_o;
    logic [6:0]  opsel_o;
    logic [4:0]  inmode_o;
    logic        op_rd_en_o;
    logic [4:0]  op_rd_addr_o;
    logic        res_en_o;
    logic [4:0]  res_rd_addr_o;
    logic        res_we_o;
    logic [4:0]  res_addr_o;

    always #2.5 clk = ~clk;

    dspseq_ctrl uut (
        .clk (clk), .rst (rst), .start_i (start_i), .instr_i (instr_i),
        .valid_o (valid_o), .alu_mode_o (alu_mode_o), .opsel_o (opsel_o),
        .inmode_o (inmode_o), .op_rd_en_o (op_rd_en_o), .op_rd_addr_o (op_rd_addr_o),
        .res_en_o (res_en_o), .res_rd_addr_o (res_rd_addr_o), .res_we_o (res_we_o),
        .res_addr_o (res_addr_o)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          m_st = 0;      // 0 idle, 1 decode, 2 execute, 3 done
    int          m_cnt = 0;
    logic [31:0] m_word = '0;   // latched instruction (0 when idle)
    logic [5:0]  m_pipe[$] = '{6'd0, 6'd0, 6'd0}; // {we, addr}, front = newest
    bit          started = 0;

    always @(posedge clk) begin
        logic [5:0] live;
        started = 1;
        live = {(m_st == 2 && m_cnt == 0 && m_word[31]), m_word[14:10]};
        if (rst) begin
            m_st = 0; m_cnt = 0; m_word = '0;
            m_pipe = '{6'd0, 6'd0, 6'd0};
        end else begin
            m_pipe.push_front(live);
            void'(m_pipe.pop_back());
            case (m_st)
                0: begin m_cnt = 0; if (start_i) m_st = 1; end
                1: begin m_word = instr_i; m_cnt = 0; m_st = 2; end
                2: begin
                    if (m_cnt == 3) begin m_cnt = 0; m_st = 3; end
                    else m_cnt++;
                end
                default: if (!start_i) begin m_st = 0; m_word = '0; end
            endcase
        end
    end

    int we_seen = 0;

    always @(negedge clk) begin
        if (started) begin
            logic       e_we;
            logic [4:0] e_addr;
            e_we   = m_pipe[2][5];
            e_addr = e_we ? m_pipe[2][4:0] : m_word[9:5];
            check(valid_o == (m_st == 3), "R7 valid", valid_o, (m_st == 3));
            check(alu_mode_o == m_word[30:27], "R3 alu", alu_mode_o, m_word[30:27]);
            check(opsel_o == m_word[26:20], "R3 opsel", opsel_o, m_word[26:20]);
            check(inmode_o == m_word[19:15], "R3 inmode", inmode_o, m_word[19:15]);
            check(op_rd_addr_o == m_word[4:0], "R3 op addr", op_rd_addr_o, m_word[4:0]);
            check(res_rd_addr_o == m_word[9:5], "R5 rd addr", res_rd_addr_o, m_word[9:5]);
            check(op_rd_en_o == m_word[31] && res_en_o == m_word[31], "R4 enables",
                  {op_rd_en_o, res_en_o}, {m_word[31], m_word[31]});
            check(res_we_o == e_we, "R8 strobe", res_we_o, e_we);
            check(res_addr_o == e_addr, "R9 port addr", res_addr_o, e_addr);
            if (res_we_o) we_seen++;
        end
    end

    // ---------------- stimulus ----------------
    task automatic run_op(input logic [31:0] w, input int hold_done,
                          input bit scramble, input bit check_len);
        int n;
        @(negedge clk);
        we_seen = 0;
        instr_i = w;
        start_i = 1'b1;
        n = 0;
        while (!valid_o && n < 40) begin
            @(negedge clk);
            n++;
            if (scramble && n == 3) instr_i = ~w; // R5: ignored after decode
        end
        if (check_len) check(n == 6, "R6 start-to-valid cycles", n, 6);
        repeat (hold_done) @(negedge clk);
        if (hold_done > 0) check(valid_o == 1'b1, "R7 done held while start high", valid_o, 1);
        start_i = 1'b0;
        @(negedge clk);
        check(valid_o == 1'b0, "R7 back to idle", valid_o, 0);
        check(alu_mode_o == 4'd0 && !res_en_o, "R5 cleared in idle", alu_mode_o, 0);
        check(we_seen == (w[31] ? 1 : 0), "R8 strobe count", we_seen, w[31] ? 1 : 0);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(valid_o == 0 && res_we_o == 0 && res_addr_o == 0 && opsel_o == 0,
              "R1 reset state", valid_o, 0);
        // R2: idle with start low stays idle
        repeat (3) @(negedge clk);
        check(valid_o == 0, "R2 idle without start", valid_o, 0);

        run_op({1'b1, 4'hA, 7'h55, 5'h13, 5'h1E, 5'h07, 5'h11}, 3, 0, 1);
        run_op({1'b0, 4'h3, 7'h2A, 5'h0C, 5'h05, 5'h19, 5'h02}, 0, 0, 1);
        run_op({1'b1, 4'h5, 7'h7F, 5'h1F, 5'h00, 5'h1F, 5'h0A}, 2, 1, 1);
        run_op({1'b1, 4'hF, 7'h01, 5'h01, 5'h15, 5'h0B, 5'h1C}, 0, 1, 1);

        // R10: reset during execute
        @(negedge clk);
        instr_i = 32'hFFFF_FFFF;
        start_i = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        start_i = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        check(valid_o == 0 && res_en_o == 0, "R10 cleared by reset", valid_o, 0);
        we_seen = 0;
        repeat (8) @(negedge clk);
        check(we_seen == 0, "R10 no stale strobe", we_seen, 0);

        for (int i = 0; i < 24; i++) begin
            logic [31:0] w;
            w = $urandom;
            run_op(w, i % 4, i[0], 1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule